// File: doc/BRIEF.md
# Packed Decimal to Binary Integer Loader

This block turns an 80-bit signed packed-decimal operand into a 64-bit two's-complement binary integer. The operand arrives on two ports: a 64-bit low word carrying sixteen 4-bit decimal digits and a 16-bit high word carrying two more digits in its low byte and the sign in its top bit. In memory the low word sits at the operand's base address and the high word at base plus 8, so a load path can present the two reads directly. Bits 14:8 of the high word play no part.

A one-cycle `start_i` pulse while the block is idle captures both words. The block then handles one digit per clock, least significant first. A running power-of-ten register is multiplied by ten each step with a shift-and-add, and each digit is multiplied into it and added to an accumulator. After the eighteenth digit the sign is applied and `done_o` pulses for one cycle with the result on `value_o`. The result holds there until the next conversion finishes. Digit nibbles above nine are not rejected; they are weighted at face value.

Top module: `bcd80_loader`

## Requirements
- R1: While reset is high and in the cycle after it, `busy_o` and `done_o` are 0 and `value_o` is 0.
- R2: A `start_i` high at a rising edge while `busy_o` is 0 captures both operand words, and `busy_o` is 1 after that edge.
- R3: `done_o` is 1 for exactly one cycle, following the 18th rising edge after the accepting edge, and `busy_o` is 0 in that cycle.
- R4: Digit k for k = 0..15 is low-word bits 4k+3:4k. Digit 16 is high-word bits 3:0 and digit 17 is high-word bits 7:4. The magnitude is the sum of digit k times 10^k.
- R5: When high-word bit 15 is 1, `value_o` is the two's-complement negation of the magnitude.
- R6: High-word bits 14:8 have no effect on the result.
- R7: A nibble of value 10 to 15 is weighted at its binary value and is not rejected.
- R8: `start_i` while `busy_o` is 1 is ignored: the running conversion keeps its operand and its timing.
- R9: `value_o` changes only in the cycle in which `done_o` is 1, and holds until the next done.
- R10: A negative sign with an all-zero magnitude gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (honoured only when idle) |
| bcd_low_i | input | 64 | Decimal digits 0 to 15, four bits each |
| bcd_high_i | input | 16 | Digits 16 and 17 in bits 7:0, sign in bit 15 |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse: `value_o` has just been updated |
| value_o | output | 64 | Signed binary result |

## Verification
`busy_o` is due one edge after the accepting edge. `done_o` and the new `value_o` are due after exactly 18 further edges, and `done_o` must be gone and `value_o` unchanged one edge after that. The bench drives and samples on falling edges and counts falling edges from the accepting edge. It checks that `done_o` is still low after the 17th edge, that it is high with the expected value after the 18th, and that the value holds after the 19th. For R8 it pulses a second start with different operands mid-run and expects the first operand's result at the original time.

// File: rtl/bcd80_pkg.sv
package bcd80_pkg;

    localparam int DIGITS   = 18;
    localparam int NIB_W    = 4;
    localparam int LOW_W    = 64;
    localparam int HIGH_W   = 16;
    localparam int RES_W    = 64;
    localparam int SIGN_BIT = 15;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Per-cycle control strobes from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // capture operand, clear accumulator
        logic step;   // fold one digit in
        logic last;   // this step is the final digit
    } ctl_t;

    // Multiply by ten as (v << 3) + (v << 1).
    function automatic logic [RES_W-1:0] times_ten(input logic [RES_W-1:0] v);
        return (v << 3) + (v << 1);
    endfunction

    // Multiply a power of ten by one nibble, using shift-and-add over its bits.
    function automatic logic [RES_W-1:0] nibble_term(input logic [NIB_W-1:0] d,
                                                     input logic [RES_W-1:0] p);
        logic [RES_W-1:0] t;
        t = '0;
        for (int b = 0; b < NIB_W; b++) begin
            if (d[b]) t = t + (p << b);
        end
        return t;
    endfunction

endpackage

// File: rtl/bcd80_ctrl.sv
module bcd80_ctrl
    import bcd80_pkg::*;
#(
    parameter int N_DIG = DIGITS,
    localparam int CNT_W = $clog2(N_DIG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output ctl_t             ctl_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] idx_o
);

    phase_e           phase_q;
    logic [CNT_W-1:0] idx_q;

    always_comb begin
        ctl_o.load = start_i && (phase_q == PH_IDLE);
        ctl_o.step = (phase_q == PH_RUN);
        ctl_o.last = ctl_o.step && (idx_q == CNT_W'(N_DIG - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    idx_q <= '0;
                    if (start_i) phase_q <= PH_RUN;
                end
                PH_RUN: begin
                    if (ctl_o.last) begin
                        phase_q <= PH_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o = (phase_q == PH_RUN);
    assign idx_o  = idx_q;

endmodule

// File: rtl/bcd80_digit_sel.sv
module bcd80_digit_sel
    import bcd80_pkg::*;
#(
    parameter int N_DIG = DIGITS,
    parameter int NW    = NIB_W,
    localparam int CNT_W = $clog2(N_DIG),
    localparam int PACK_W = N_DIG * NW
) (
    input  logic [PACK_W-1:0] digits_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic [NW-1:0]     digit_o
);

    logic [NW-1:0] dig [N_DIG];

    for (genvar g = 0; g < N_DIG; g++) begin : g_unpack
        assign dig[g] = digits_i[g*NW +: NW];
    end

    always_comb begin
        digit_o = '0;
        for (int k = 0; k < N_DIG; k++) begin
            if (idx_i == CNT_W'(k)) digit_o = dig[k];
        end
    end

endmodule

// File: rtl/bcd80_accum.sv
module bcd80_accum
    import bcd80_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl_i,
    input  logic             neg_i,
    input  logic [NIB_W-1:0] digit_i,
    output logic [RW-1:0]    value_o,
    output logic             done_o
);

    logic [RW-1:0] pow_q;
    logic [RW-1:0] acc_q;
    logic [RW-1:0] sum;

    assign sum = acc_q + nibble_term(digit_i, pow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pow_q   <= RW'(1);
            acc_q   <= '0;
            value_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (ctl_i.load) begin
                pow_q <= RW'(1);
                acc_q <= '0;
            end else if (ctl_i.step) begin
                acc_q <= sum;
                pow_q <= times_ten(pow_q);
                if (ctl_i.last) begin
                    value_o <= neg_i ? (~sum + RW'(1)) : sum;
                    done_o  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bcd80_loader.sv
module bcd80_loader
    import bcd80_pkg::*;
#(
    parameter int N_DIG = DIGITS,
    parameter int LW    = LOW_W,
    parameter int HW    = HIGH_W,
    parameter int RW    = RES_W,
    parameter int SB    = SIGN_BIT,
    localparam int CNT_W   = $clog2(N_DIG),
    localparam int PACK_W  = N_DIG * NIB_W,
    localparam int HI_DIGW = PACK_W - LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [LW-1:0] bcd_low_i,
    input  logic [HW-1:0] bcd_high_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [RW-1:0] value_o
);

    ctl_t              ctl;
    logic [CNT_W-1:0]  idx;
    logic [PACK_W-1:0] digits_q;
    logic              neg_q;
    logic [NIB_W-1:0]  digit;

    bcd80_ctrl #(.N_DIG(N_DIG)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .busy_o  (busy_o),
        .idx_o   (idx)
    );

    // Operand capture: the high word contributes only its digit byte and sign.
    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q <= '0;
            neg_q    <= 1'b0;
        end else if (ctl.load) begin
            digits_q <= {bcd_high_i[HI_DIGW-1:0], bcd_low_i};
            neg_q    <= bcd_high_i[SB];
        end
    end

    bcd80_digit_sel #(.N_DIG(N_DIG), .NW(NIB_W)) u_sel (
        .digits_i (digits_q),
        .idx_i    (idx),
        .digit_o  (digit)
    );

    bcd80_accum #(.RW(RW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .neg_i   (neg_q),
        .digit_i (digit),
        .value_o (value_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/bcd80_loader_chk.sv
module bcd80_loader_chk #(
    parameter int N_DIG = 18,
    parameter int RW    = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [RW-1:0] value_o
);

    logic [7:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst)                     lat_q <= '0;
        else if (start_i && !busy_o) lat_q <= '0;
        else if (busy_o)             lat_q <= lat_q + 8'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && value_o == '0));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_q == 8'(N_DIG)));

    assert_value_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(value_o));

endmodule

bind bcd80_loader bcd80_loader_chk #(.N_DIG(N_DIG), .RW(RW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .value_o (value_o)
);

// File: tb/tb_bcd80_loader.sv
`timescale 1ns/1ps
module tb_bcd80_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [63:0] bcd_low_i = '0;
    logic [15:0] bcd_high_i = '0;
    logic        busy_o, done_o;
    logic [63:0] value_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bcd80_loader dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .bcd_low_i(bcd_low_i), .bcd_high_i(bcd_high_i),
        .busy_o(busy_o), .done_o(done_o), .value_o(value_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result from the requirements R4, R5, R7 (R6: bits 14:8 unused).
    function automatic logic [63:0] ref_value(input logic [63:0] lo, input logic [15:0] hi);
        logic [63:0] s, p;
        logic [71:0] d;
        s = '0;
        p = 64'd1;
        d = {hi[7:0], lo};
        for (int k = 0; k < 18; k++) begin
            s = s + 64'(d[4*k +: 4]) * p;
            p = p * 64'd10;
        end
        if (hi[15]) s = -s;
        return s;
    endfunction

    // Run one conversion; optionally pulse a second start mid-run (R8).
    task automatic convert(input logic [63:0] lo, input logic [15:0] hi, input string req,
                           input bit poke, input logic [63:0] lo2, input logic [15:0] hi2);
        logic [63:0] exp;
        exp = ref_value(lo, hi);
        @(negedge clk);
        bcd_low_i = lo; bcd_high_i = hi; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after accept", 64'(busy_o), 64'd1);
        for (int n = 1; n < 17; n++) begin
            @(negedge clk);
            if (poke && n == 5) begin
                bcd_low_i = lo2; bcd_high_i = hi2; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R3 done not early", 64'(done_o), 64'd0);
        @(negedge clk);
        chk(done_o == 1'b1, "R3 done on 18th edge", 64'(done_o), 64'd1);
        chk(busy_o == 1'b0, "R3 idle at done", 64'(busy_o), 64'd0);
        chk(value_o == exp, req, value_o, exp);
        @(negedge clk);
        chk(done_o == 1'b0, "R3 done single cycle", 64'(done_o), 64'd0);
        chk(value_o == exp, "R9 value holds", value_o, exp);
    endtask

    function automatic logic [63:0] rand_dec_low();
        logic [63:0] v;
        for (int k = 0; k < 16; k++) v[4*k +: 4] = 4'($urandom_range(9, 0));
        return v;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0BCD));
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", {62'd0, busy_o, done_o}, 64'd0);
        chk(value_o == '0, "R1 value in reset", value_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && value_o == '0, "R1 after reset",
            value_o, 64'd0);

        convert(64'd0, 16'h0000, "R4 all zero", 1'b0, '0, '0);
        convert(64'h1, 16'h0000, "R4 digit 0 only", 1'b0, '0, '0);
        convert(64'h0, 16'h0090, "R4 digit 17 only", 1'b0, '0, '0);
        convert(64'h9999_9999_9999_9999, 16'h0099, "R4 eighteen nines", 1'b0, '0, '0);
        convert(64'h0123_4567_8901_2345, 16'h0067, "R4 mixed digits", 1'b0, '0, '0);
        convert(64'h5, 16'h8001, "R5 negative", 1'b0, '0, '0);
        convert(64'h9999_9999_9999_9999, 16'h8099, "R5 most negative", 1'b0, '0, '0);
        convert(64'h0, 16'h8000, "R10 negative zero", 1'b0, '0, '0);
        chk(value_o == 64'd0, "R10 result is zero", value_o, 64'd0);
        convert(64'h42, 16'h7F12, "R6 bits 14:8 set", 1'b0, '0, '0);
        chk(value_o == ref_value(64'h42, 16'h0012), "R6 equals clean high word",
            value_o, ref_value(64'h42, 16'h0012));
        convert(64'hF, 16'h0000, "R7 nibble F", 1'b0, '0, '0);
        chk(value_o == 64'd15, "R7 face value 15", value_o, 64'd15);
        convert(64'hA0, 16'h00FF, "R7 high nibbles", 1'b0, '0, '0);
        convert(64'h7, 16'h0000, "R8 start while busy", 1'b1, 64'h9999, 16'h8099);
        chk(value_o == 64'd7, "R8 first operand kept", value_o, 64'd7);

        for (int i = 0; i < 40; i++) begin
            convert(rand_dec_low(), {1'($urandom_range(1, 0)), 7'd0,
                    4'($urandom_range(9, 0)), 4'($urandom_range(9, 0))},
                    "R4 R5 random decimal", 1'b0, '0, '0);
        end
        for (int i = 0; i < 20; i++) begin
            convert({$urandom(), $urandom()}, 16'($urandom()),
                    "R6 R7 random raw", 1'b0, '0, '0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule